// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Repeat

This block is the sending half of an asynchronous smart card link running the character protocol. The host places one byte in a holding register. When the transmitter is enabled and the byte is waiting, it moves into a frame register on the next rate tick. The block then drives a start bit, the eight data bits least significant first, and an even parity bit onto a single open-drain I/O line. Each bit lasts a fixed number of rate ticks.

After the parity bit, the block releases the line for one elementary time unit (etu). It samples the line in the middle of that etu. A receiver that pulls the line low there has rejected the character. The block then raises a sticky error flag and waits for the line to return high. It resends the same frame automatically, and does not report completion. A frame that passes cleanly sets the transmit-end flag.

A retry limit guards against a card that rejects a character forever. When the limit is reached, the character is dropped and a sticky overflow flag stops all further sending until the host clears it. Both interrupt outputs are the matching flag gated by an enable bit.

Top module: `card_char_tx`

## Requirements
- R1: After reset, `dataEmpty`=1, `txEnd`=1, `errFlag`=0, `overrun`=0, `retryOvf`=0 and `lineDriveLow`=0.
- R2: A `hostWrEn` pulse while `dataEmpty`=1 stores `hostWrData`. On the next cycle `dataEmpty` and `txEnd` both read 0.
- R3: A `hostWrEn` pulse while `dataEmpty`=0 leaves the held byte unchanged and sets the sticky `overrun` flag. A pulse on `flagClr` bit 1 clears `overrun`.
- R4: The held byte moves into the frame register on an `etuTick` cycle. This happens only when `txEnable`=1, `retryOvf`=0 and no frame is in progress, and `dataEmpty` then returns to 1. While `txEnable`=0 nothing is loaded and the line is not driven.
- R5: Each frame is one start bit (low), then D0 to D7, then an even parity bit, so that the data bits plus parity hold an even number of ones. Each bit lasts `TICKS_PER_ETU` ticks. `lineDriveLow`=1 pulls the line low, and the output changes only on `etuTick` cycles.
- R6: The etu after the parity bit is an error window. The line is released during it and sampled at its middle. A low sample sets `errFlag`, and `txEnd` stays 0 while the character is repeated.
- R7: An errored frame is resent with the same byte. The repeat's start bit begins after two more etus, counted from the first etu whose mid-point sample sees the line high again. With a two-etu error pulse, a repeat starts 14 etus after the previous start.
- R8: A frame whose error window samples high sets `txEnd` to 1 and leaves `errFlag` unchanged.
- R9: `errFlag` stays set until a pulse on `flagClr` bit 0 clears it.
- R10: `errIrq` is high exactly when `errFlag`=1 and `errIrqEn`=1. `endIrq` is high exactly when `txEnd`=1 and `endIrqEn`=1.
- R11: If the original frame and `MAX_RETRY` repeats are all rejected, the block sets `retryOvf` and drops the character, and `txEnd` stays 0. No byte is loaded until a pulse on `flagClr` bit 2 clears `retryOvf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| txEnable | input | 1 | Allows bytes to be loaded and sent |
| errIrqEn | input | 1 | Enables the error interrupt |
| endIrqEn | input | 1 | Enables the transmit-end interrupt |
| hostWrEn | input | 1 | Host write strobe for the holding register |
| hostWrData | input | 8 | Byte to send |
| flagClr | input | 3 | Clear pulses: bit 0 error, bit 1 overrun, bit 2 retry overflow |
| etuTick | input | 1 | Single-cycle rate tick, `TICKS_PER_ETU` per bit |
| lineIn | input | 1 | Sampled level of the I/O line |
| lineDriveLow | output | 1 | 1 pulls the open-drain line low |
| dataEmpty | output | 1 | Holding register free |
| txEnd | output | 1 | Last character completed cleanly |
| errFlag | output | 1 | Sticky: receiver signalled an error |
| overrun | output | 1 | Sticky: write arrived while a byte was held |
| retryOvf | output | 1 | Sticky: retry limit exceeded |
| errIrq | output | 1 | Error interrupt request |
| endIrq | output | 1 | Transmit-end interrupt request |

## Verification
The properties take several things for granted about the inputs. `etuTick` is a single-cycle pulse, `TICKS_PER_ETU` is at least three, and `lineIn` is already synchronous to `clk`, since no synchronizer sits in front of the mid-etu sample. They also assume that host writes and clear requests are one-cycle pulses. The stimulus stays inside these limits: ticks come on every other cycle and every input changes on the falling clock edge. The emulated card moves the line only just after a tick edge, and it holds each error pulse for exactly two whole etus, so the repeat spacing has one defined value.

// File: rtl/card_tx_pkg.sv
package card_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 2;      // start + data + parity
  localparam int IDX_W   = $clog2(FRAME_W);

  // Bit positions inside the flagClr request vector
  localparam int CLR_ERR   = 0;
  localparam int CLR_OVR   = 1;
  localparam int CLR_RETRY = 2;
  localparam int CLR_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEND   = 3'd1,
    ST_WINDOW = 3'd2,
    ST_WAITHI = 3'd3,
    ST_GAP    = 3'd4
  } txState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             holdWrite;
    logic             loadFrame;
    logic             driveEn;
    logic [IDX_W-1:0] bitSel;
    logic             sampleMid;
  } dpStrobe_t;

  function automatic logic evenParity(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

endpackage

// File: rtl/card_tx_datapath.sv
module card_tx_datapath
  import card_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              lineIn,
  output logic              lineDriveLow,
  output logic              lineLowSeen
);

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] frameReg;

  // Holding register: written only when the control accepts the byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobe.holdWrite) begin
      holdReg <= hostWrData;
    end
  end

  // Frame register: bit 0 is the start bit, top bit the parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
    end else if (strobe.loadFrame) begin
      frameReg <= {evenParity(holdReg), holdReg, 1'b0};
    end
  end

  // Mid-etu capture of the line during the window and while waiting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineLowSeen <= 1'b0;
    end else if (strobe.sampleMid) begin
      lineLowSeen <= ~lineIn;
    end
  end

  // Open-drain drive: pull low only for a zero bit inside the frame
  always_comb begin
    lineDriveLow = 1'b0;
    if (strobe.driveEn && (strobe.bitSel < IDX_W'(FRAME_W))) begin
      lineDriveLow = ~frameReg[strobe.bitSel];
    end
  end

endmodule

// File: rtl/card_tx_control.sv
module card_tx_control
  import card_tx_pkg::*;
#(
  parameter int TICKS_PER_ETU = 4,
  parameter int MAX_RETRY     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             hostWrEn,
  input  logic [CLR_W-1:0] flagClr,
  input  logic             etuTick,
  input  logic             lineLowSeen,
  output dpStrobe_t        strobe,
  output logic             dataEmpty,
  output logic             txEnd,
  output logic             errFlag,
  output logic             overrun,
  output logic             retryOvf
);

  localparam int TICK_W   = (TICKS_PER_ETU > 1) ? $clog2(TICKS_PER_ETU) : 1;
  localparam int HALF     = (TICKS_PER_ETU - 1) / 2;
  localparam int RETRY_W  = $clog2(MAX_RETRY + 1) > 0 ? $clog2(MAX_RETRY + 1) : 1;
  localparam logic [TICK_W-1:0]  TICK_LAST = TICK_W'(TICKS_PER_ETU - 1);
  localparam logic [TICK_W-1:0]  TICK_MID  = TICK_W'(HALF);
  localparam logic [IDX_W-1:0]   BIT_LAST  = IDX_W'(FRAME_W - 1);
  localparam logic [RETRY_W-1:0] RETRY_MAX = RETRY_W'(MAX_RETRY);

  txState_t           state, stateNx;
  logic [TICK_W-1:0]  tickCnt;
  logic [IDX_W-1:0]   bitIdx, bitIdxNx;
  logic [RETRY_W-1:0] retryCnt;

  logic etuEnd, midTick, wrAccept, wrReject, startOk;
  logic frameErr, frameClean, retryBump, ovfHit;

  assign etuEnd   = etuTick && (tickCnt == TICK_LAST);
  assign midTick  = etuTick && (tickCnt == TICK_MID);
  assign wrAccept = hostWrEn && dataEmpty;
  assign wrReject = hostWrEn && !dataEmpty;
  assign startOk  = (state == ST_IDLE) && etuTick && txEnable &&
                    !dataEmpty && !retryOvf;

  // Next-state logic
  always_comb begin
    stateNx    = state;
    bitIdxNx   = bitIdx;
    frameErr   = 1'b0;
    frameClean = 1'b0;
    retryBump  = 1'b0;
    ovfHit     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startOk) begin
          stateNx  = ST_SEND;
          bitIdxNx = '0;
        end
      end
      ST_SEND: begin
        if (etuEnd) begin
          if (bitIdx == BIT_LAST) stateNx = ST_WINDOW;
          else                    bitIdxNx = bitIdx + 1'b1;
        end
      end
      ST_WINDOW: begin
        if (etuEnd) begin
          if (lineLowSeen) begin
            frameErr = 1'b1;
            if (retryCnt == RETRY_MAX) begin
              ovfHit  = 1'b1;
              stateNx = ST_IDLE;
            end else begin
              retryBump = 1'b1;
              stateNx   = ST_WAITHI;
            end
          end else begin
            frameClean = 1'b1;
            stateNx    = ST_IDLE;
          end
        end
      end
      ST_WAITHI: begin
        if (etuEnd && !lineLowSeen) stateNx = ST_GAP;
      end
      ST_GAP: begin
        if (etuEnd) begin
          stateNx  = ST_SEND;
          bitIdxNx = '0;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  // Sequencing registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      tickCnt  <= '0;
      retryCnt <= '0;
    end else begin
      state  <= stateNx;
      bitIdx <= bitIdxNx;
      if (state == ST_IDLE) begin
        tickCnt <= '0;
      end else if (etuTick) begin
        tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
      end
      if (startOk)        retryCnt <= '0;
      else if (retryBump) retryCnt <= retryCnt + 1'b1;
    end
  end

  // Status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataEmpty <= 1'b1;
      txEnd     <= 1'b1;
      errFlag   <= 1'b0;
      overrun   <= 1'b0;
      retryOvf  <= 1'b0;
    end else begin
      if (startOk)       dataEmpty <= 1'b1;
      else if (wrAccept) dataEmpty <= 1'b0;

      if (wrAccept)        txEnd <= 1'b0;
      else if (frameClean) txEnd <= 1'b1;

      if (frameErr)                errFlag <= 1'b1;
      else if (flagClr[CLR_ERR])   errFlag <= 1'b0;

      if (wrReject)                overrun <= 1'b1;
      else if (flagClr[CLR_OVR])   overrun <= 1'b0;

      if (ovfHit)                  retryOvf <= 1'b1;
      else if (flagClr[CLR_RETRY]) retryOvf <= 1'b0;
    end
  end

  always_comb begin
    strobe.holdWrite = wrAccept;
    strobe.loadFrame = startOk;
    strobe.driveEn   = (state == ST_SEND);
    strobe.bitSel    = bitIdx;
    strobe.sampleMid = midTick && ((state == ST_WINDOW) || (state == ST_WAITHI));
  end

endmodule

// File: rtl/card_char_tx.sv
module card_char_tx
  import card_tx_pkg::*;
#(
  parameter int TICKS_PER_ETU = 4,
  parameter int MAX_RETRY     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             errIrqEn,
  input  logic             endIrqEn,
  input  logic             hostWrEn,
  input  logic [7:0]       hostWrData,
  input  logic [2:0]       flagClr,
  input  logic             etuTick,
  input  logic             lineIn,
  output logic             lineDriveLow,
  output logic             dataEmpty,
  output logic             txEnd,
  output logic             errFlag,
  output logic             overrun,
  output logic             retryOvf,
  output logic             errIrq,
  output logic             endIrq
);

  dpStrobe_t strobe;
  logic      lineLowSeen;

  card_tx_control #(
    .TICKS_PER_ETU(TICKS_PER_ETU),
    .MAX_RETRY    (MAX_RETRY)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEnable   (txEnable),
    .hostWrEn   (hostWrEn),
    .flagClr    (flagClr),
    .etuTick    (etuTick),
    .lineLowSeen(lineLowSeen),
    .strobe     (strobe),
    .dataEmpty  (dataEmpty),
    .txEnd      (txEnd),
    .errFlag    (errFlag),
    .overrun    (overrun),
    .retryOvf   (retryOvf)
  );

  card_tx_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostWrData  (hostWrData),
    .lineIn      (lineIn),
    .lineDriveLow(lineDriveLow),
    .lineLowSeen (lineLowSeen)
  );

  assign errIrq = errFlag & errIrqEn;
  assign endIrq = txEnd & endIrqEn;

endmodule

// File: rtl/card_char_tx_chk.sv
module card_char_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txEnable,
  input logic       hostWrEn,
  input logic [2:0] flagClr,
  input logic       etuTick,
  input logic       lineDriveLow,
  input logic       dataEmpty,
  input logic       txEnd,
  input logic       errFlag,
  input logic       overrun,
  input logic       retryOvf
);

  p_write_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && dataEmpty) |=> (!dataEmpty && !txEnd));

  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !dataEmpty) |=> overrun);

  p_load_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEmpty) |-> ($past(etuTick) && $past(txEnable) && !$past(retryOvf)));

  p_drive_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineDriveLow) |-> $past(etuTick));

  p_end_not_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> !$rose(errFlag));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !flagClr[0]) |=> errFlag);

  p_silent_ovf_r11: assert property (@(posedge clk) disable iff (!rstN)
    retryOvf |-> !lineDriveLow);

endmodule

bind card_char_tx card_char_tx_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txEnable    (txEnable),
  .hostWrEn    (hostWrEn),
  .flagClr     (flagClr),
  .etuTick     (etuTick),
  .lineDriveLow(lineDriveLow),
  .dataEmpty   (dataEmpty),
  .txEnd       (txEnd),
  .errFlag     (errFlag),
  .overrun     (overrun),
  .retryOvf    (retryOvf)
);

// File: tb/card_char_tx_bench.sv
`timescale 1ns/1ps
module card_char_tx_bench;

  localparam int T      = 4;
  localparam int MAXR   = 3;
  localparam int DIV    = 2;
  localparam int HALF_B = T / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0, errIrqEn = 1'b0, endIrqEn = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic [2:0] flagClr = 3'b000;
  logic       etuTick = 1'b0;
  logic       cardLow = 1'b0;
  logic       lineIn;
  logic       lineDriveLow, dataEmpty, txEnd, errFlag, overrun, retryOvf, errIrq, endIrq;

  int nChecks = 0, nBad = 0;
  int tickNum = 0;
  int injectErr = 0;
  int rxFrames = 0;
  int lastGap = 0;
  int lastStart = -1;
  logic [7:0] rxLast = 8'h00;

  always #5 clk = ~clk;

  assign lineIn = ~(lineDriveLow | cardLow);

  card_char_tx #(.TICKS_PER_ETU(T), .MAX_RETRY(MAXR)) u_card_char_tx (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .errIrqEn(errIrqEn),
    .endIrqEn(endIrqEn), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .flagClr(flagClr), .etuTick(etuTick), .lineIn(lineIn),
    .lineDriveLow(lineDriveLow), .dataEmpty(dataEmpty), .txEnd(txEnd),
    .errFlag(errFlag), .overrun(overrun), .retryOvf(retryOvf),
    .errIrq(errIrq), .endIrq(endIrq)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Rate tick, one pulse every DIV cycles, changed away from the active edge
  initial begin
    int divCnt;
    divCnt = 0;
    forever begin
      @(negedge clk);
      divCnt  = (divCnt == DIV - 1) ? 0 : divCnt + 1;
      etuTick = (divCnt == DIV - 1);
    end
  end

  always @(posedge clk) begin
    if (!rstN) tickNum <= 0;
    else if (etuTick) tickNum <= tickNum + 1;
  end

  // Card model: decodes frames and pulls the line low in the error window on demand
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && lineDriveLow) begin
        int s;
        logic [9:0] bits;
        s = tickNum;
        if (lastStart >= 0) lastGap = s - lastStart;
        lastStart = s;
        for (int k = 0; k < 10; k++) begin
          while (tickNum != s + k*T + HALF_B) @(negedge clk);
          bits[k] = ~lineDriveLow;
        end
        while (tickNum != s + 10*T) @(negedge clk);
        if (injectErr > 0) begin
          cardLow = 1'b1;
          while (tickNum != s + 10*T + HALF_B) @(negedge clk);
          chkEq("R6 line released in window", int'(lineDriveLow), 0);
          while (tickNum != s + 12*T) @(negedge clk);
          cardLow = 1'b0;
          chkEq("R6 no end flag while repeating", int'(txEnd), 0);
          injectErr--;
        end else begin
          while (tickNum != s + 10*T + HALF_B) @(negedge clk);
          chkEq("R6 line released in window", int'(lineDriveLow), 0);
          while (tickNum != s + 11*T) @(negedge clk);
        end
        chkEq("R5 start bit low", int'(bits[0]), 0);
        chkEq("R5 even parity", int'(^bits[9:1]), 0);
        rxLast = bits[8:1];
        rxFrames++;
      end
    end
  end

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    hostWrEn = 1'b1;
    hostWrData = b;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic pulseClr(input logic [2:0] m);
    @(negedge clk);
    flagClr = m;
    @(negedge clk);
    flagClr = 3'b000;
  endtask

  task automatic waitDone();
    int n;
    n = 0;
    while (!(txEnd || retryOvf) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) chkEq("R8 completion timeout", 0, 1);
    repeat (3*T*DIV) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] b, input int nErr);
    int f0, expF;
    f0 = rxFrames;
    injectErr = nErr;
    writeByte(b);
    chkEq("R2 empty cleared by write", int'(dataEmpty), 0);
    chkEq("R2 end cleared by write", int'(txEnd), 0);
    waitDone();
    expF = (nErr > MAXR) ? MAXR + 1 : nErr + 1;
    chkEq("R7 frame count", rxFrames - f0, expF);
    chkEq("R5 byte on line", int'(rxLast), int'(b));
    chkEq("R4 empty after load", int'(dataEmpty), 1);
    if (nErr <= MAXR) begin
      chkEq("R8 end flag set", int'(txEnd), 1);
      chkEq("R6 error flag", int'(errFlag), int'(nErr > 0));
      chkEq("R10 error irq", int'(errIrq), int'((nErr > 0) && errIrqEn));
      chkEq("R10 end irq", int'(endIrq), int'(endIrqEn));
      if (nErr > 0) chkEq("R7 repeat spacing", lastGap, 14*T);
    end else begin
      chkEq("R11 overflow flag", int'(retryOvf), 1);
      chkEq("R11 no end flag", int'(txEnd), 0);
    end
    if (errFlag) begin
      pulseClr(3'b001);
      chkEq("R9 error flag cleared", int'(errFlag), 0);
    end
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nBad++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(32'd20240));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 dataEmpty", int'(dataEmpty), 1);
    chkEq("R1 txEnd", int'(txEnd), 1);
    chkEq("R1 errFlag", int'(errFlag), 0);
    chkEq("R1 overrun", int'(overrun), 0);
    chkEq("R1 retryOvf", int'(retryOvf), 0);
    chkEq("R1 line idle", int'(lineDriveLow), 0);

    // R4 and R3: disabled transmitter holds the byte; second write overruns
    f0 = rxFrames;
    writeByte(8'hA5);
    chkEq("R2 empty cleared", int'(dataEmpty), 0);
    repeat (40) @(negedge clk);
    chkEq("R4 no frame while disabled", rxFrames - f0, 0);
    chkEq("R4 byte still held", int'(dataEmpty), 0);
    writeByte(8'h3C);
    chkEq("R3 overrun set", int'(overrun), 1);
    chkEq("R3 still full", int'(dataEmpty), 0);
    txEnable = 1'b1;
    waitDone();
    chkEq("R3 first byte kept", int'(rxLast), 8'hA5);
    chkEq("R3 single frame", rxFrames - f0, 1);
    pulseClr(3'b010);
    chkEq("R3 overrun cleared", int'(overrun), 0);

    // Directed corner patterns
    errIrqEn = 1'b1;
    endIrqEn = 1'b1;
    sendChar(8'h00, 0);
    sendChar(8'hFF, 1);
    sendChar(8'h81, 2);
    sendChar(8'h6E, MAXR);

    // R11: retry limit exceeded, then the next byte waits for the clear
    sendChar(8'h5A, MAXR + 1);
    f0 = rxFrames;
    injectErr = 0;
    writeByte(8'h77);
    repeat (300) @(negedge clk);
    chkEq("R11 blocked while overflowed", rxFrames - f0, 0);
    chkEq("R11 byte held", int'(dataEmpty), 0);
    pulseClr(3'b100);
    chkEq("R11 overflow cleared", int'(retryOvf), 0);
    waitDone();
    chkEq("R11 sends after clear", int'(rxLast), 8'h77);
    chkEq("R11 end after clear", int'(txEnd), 1);
    if (errFlag) pulseClr(3'b001);

    // Random characters, error counts and interrupt enables
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      int ne;
      b = 8'($urandom_range(0, 255));
      ne = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 2)) : 0;
      errIrqEn = 1'($urandom_range(0, 1));
      endIrqEn = 1'($urandom_range(0, 1));
      sendChar(b, ne);
    end

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule